// File: doc/BRIEF.md
# Dual-Exponent Modular Exponentiation Sequencer

This block sequences a Montgomery multiplier through a simultaneous exponentiation that yields g0^e0 · g1^e1 mod m. The host first loads four operand slots: slot 0 holds the Montgomery form of g0, slot 1 holds that of g1, slot 2 holds their product, and slot 3 is the accumulator, preset to R mod m. The host then pushes the two exponents into an on-block queue. Each 32-bit entry packs a 16-bit slice of each exponent, and entries are pushed most significant slice first.

With the auto level low, a one-cycle start pulse runs one multiplication whose x, y and destination slots are chosen by the host. This covers the pre- and post-computation steps. With the auto level high, the same pulse begins a full run. The run takes one queue entry at a time and walks its bit pairs from the top bit down. For each pair it squares the accumulator. If either bit of the pair is set, it then multiplies the accumulator by the matching precomputed slot. Every result goes back into slot 3. The run stops once an entry is finished and the queue is empty.

The multiplier itself is outside the block. The block drives it through a start pulse with slot selects and waits for a done pulse.

Top module: `sexp_sequencer`

## Requirements
- R1: A queue entry holds the e1 slice in bits 31:16 and the e0 slice in bits 15:0. Entries are used in push order, oldest first. Within an entry, bit pairs are taken from bit 15 down to bit 0.
- R2: In auto mode each bit pair (e1,e0) first issues a squaring with x=3, y=3 and destination 3. It then issues x=3, destination 3 with y=0 for pair 01, y=1 for pair 10 and y=2 for pair 11. No second multiplication is issued for pair 00. Over n entries the run therefore issues 16·n plus popcount(e0|e1) multiplications.
- R3: An auto run ends after the last bit of an entry when the queue is empty. If the queue is empty when start arrives, ready_o is asserted in the cycle after start is sampled and no multiplication is issued.
- R4: In single mode, mul_start_o pulses in the cycle after start is sampled. mul_x_o, mul_y_o and mul_dest_o carry the selects sampled with start and stay stable until mul_done_i. ready_o follows in the cycle after mul_done_i.
- R5: ready_o is high for exactly one cycle per operation.
- R6: start_i is ignored while a single or auto operation is in progress.
- R7: mul_start_o is a single-cycle pulse and is never raised while a multiplication is outstanding.
- R8: fifo_full_o is high while the queue holds DEPTH entries. A push while full is dropped without changing the stored entries, and fifo_nopush_o pulses in the following cycle.
- R9: During reset, ready_o, mul_start_o, fifo_full_o and fifo_nopush_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_din_i | input | 32 | Queue entry: e1 slice in 31:16, e0 slice in 15:0 |
| fifo_push_i | input | 1 | Push fifo_din_i into the queue |
| fifo_full_o | output | 1 | Queue holds DEPTH entries |
| fifo_nopush_o | output | 1 | One-cycle flag after a refused push |
| start_i | input | 1 | One-cycle start pulse |
| run_auto_i | input | 1 | High: full exponentiation; low: one multiplication |
| x_sel_i | input | 2 | Single mode x slot |
| y_sel_i | input | 2 | Single mode y slot |
| dest_sel_i | input | 2 | Single mode destination slot |
| ready_o | output | 1 | One-cycle completion pulse |
| mul_start_o | output | 1 | Start pulse to the multiplier |
| mul_x_o | output | 2 | x slot for the multiplier |
| mul_y_o | output | 2 | y slot for the multiplier |
| mul_dest_o | output | 2 | Destination slot for the multiplier |
| mul_done_i | input | 1 | Done pulse from the multiplier |

## Verification
In single mode, mul_start_o is due one cycle after the edge that samples start, and ready_o one cycle after the edge that samples mul_done_i. With an empty queue, ready_o is due one cycle after start. A refused push shows on fifo_nopush_o one cycle after the push edge. The bench changes inputs on falling edges and samples at the falling edge where each of these results should first appear. A multiplier model answers each start after a fixed latency and performs the modular product on small integers, so auto runs are judged by their final accumulator, their multiplication count and a ready pulse that lasts one cycle. Everything is compared against g0^e0·g1^e1 computed separately by plain exponentiation.

// File: rtl/sexp_pkg.sv
package sexp_pkg;
  localparam logic [1:0] OP_G0  = 2'd0;
  localparam logic [1:0] OP_G1  = 2'd1;
  localparam logic [1:0] OP_G01 = 2'd2;
  localparam logic [1:0] OP_ACC = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SGL_ISSUE, ST_SGL_WAIT, ST_POP, ST_SQ_ISSUE,
    ST_SQ_WAIT, ST_MUL_ISSUE, ST_MUL_WAIT, ST_NEXT, ST_DONE
  } seq_state_e;

  // pair = {e1 bit, e0 bit}
  function automatic logic [1:0] pair_to_op(input logic [1:0] pair);
    case (pair)
      2'b01:   return OP_G0;
      2'b10:   return OP_G1;
      default: return OP_G01;
    endcase
  endfunction
endpackage

// File: rtl/sexp_fifo.sv
module sexp_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             nopush_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             nopush_q;
  logic             do_push, do_pop;

  assign full_o   = (count_q == CW'(DEPTH));
  assign empty_o  = (count_q == '0);
  assign do_push  = push_i & ~full_o;
  assign do_pop   = pop_i & ~empty_o;
  assign dout_o   = mem_q[rd_ptr_q];
  assign nopush_o = nopush_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      nopush_q <= 1'b0;
    end else begin
      nopush_q <= push_i & full_o;
      if (do_push) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sexp_pair_shifter.sv
module sexp_pair_shifter #(
  parameter int SLICE_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic                 shift_i,
  input  logic [2*SLICE_W-1:0] din_i,
  output logic [1:0]           pair_o,
  output logic                 last_o
);
  localparam int CNT_W = $clog2(SLICE_W);

  logic [SLICE_W-1:0] e1_q, e0_q;
  logic [CNT_W-1:0]   cnt_q;

  assign pair_o = {e1_q[SLICE_W-1], e0_q[SLICE_W-1]};
  assign last_o = (cnt_q == CNT_W'(SLICE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1_q  <= '0;
      e0_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      e1_q  <= din_i[2*SLICE_W-1:SLICE_W];
      e0_q  <= din_i[SLICE_W-1:0];
      cnt_q <= '0;
    end else if (shift_i) begin
      e1_q  <= e1_q << 1;
      e0_q  <= e0_q << 1;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sexp_ctrl.sv
module sexp_ctrl
  import sexp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       run_auto_i,
  input  logic [1:0] x_sel_i,
  input  logic [1:0] y_sel_i,
  input  logic [1:0] dest_sel_i,
  input  logic       fifo_empty_i,
  input  logic [1:0] pair_i,
  input  logic       last_i,
  input  logic       mul_done_i,
  output logic       fifo_pop_o,
  output logic       load_o,
  output logic       shift_o,
  output logic       mul_start_o,
  output logic [1:0] mul_x_o,
  output logic [1:0] mul_y_o,
  output logic [1:0] mul_dest_o,
  output logic       ready_o
);
  seq_state_e state_q, state_d;
  logic [1:0] x_q, x_d, y_q, y_d, d_q, d_d;

  always_comb begin
    state_d    = state_q;
    x_d        = x_q;
    y_d        = y_q;
    d_d        = d_q;
    fifo_pop_o = 1'b0;
    load_o     = 1'b0;
    shift_o    = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        if (run_auto_i) begin
          state_d = fifo_empty_i ? ST_DONE : ST_POP;
        end else begin
          x_d     = x_sel_i;
          y_d     = y_sel_i;
          d_d     = dest_sel_i;
          state_d = ST_SGL_ISSUE;
        end
      end
      ST_SGL_ISSUE: state_d = ST_SGL_WAIT;
      ST_SGL_WAIT:  if (mul_done_i) state_d = ST_DONE;
      ST_POP: begin
        fifo_pop_o = 1'b1;
        load_o     = 1'b1;
        x_d        = OP_ACC;
        y_d        = OP_ACC;
        d_d        = OP_ACC;
        state_d    = ST_SQ_ISSUE;
      end
      ST_SQ_ISSUE: state_d = ST_SQ_WAIT;
      ST_SQ_WAIT: if (mul_done_i) begin
        if (pair_i != 2'b00) begin
          y_d     = pair_to_op(pair_i);
          state_d = ST_MUL_ISSUE;
        end else begin
          state_d = ST_NEXT;
        end
      end
      ST_MUL_ISSUE: state_d = ST_MUL_WAIT;
      ST_MUL_WAIT:  if (mul_done_i) state_d = ST_NEXT;
      ST_NEXT: begin
        shift_o = 1'b1;
        if (last_i) begin
          state_d = fifo_empty_i ? ST_DONE : ST_POP;
        end else begin
          y_d     = OP_ACC;
          state_d = ST_SQ_ISSUE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      d_q     <= '0;
    end else begin
      state_q <= state_d;
      x_q     <= x_d;
      y_q     <= y_d;
      d_q     <= d_d;
    end
  end

  assign mul_start_o = (state_q == ST_SGL_ISSUE) || (state_q == ST_SQ_ISSUE) ||
                       (state_q == ST_MUL_ISSUE);
  assign ready_o     = (state_q == ST_DONE);
  assign mul_x_o     = x_q;
  assign mul_y_o     = y_q;
  assign mul_dest_o  = d_q;
endmodule

// File: rtl/sexp_sequencer.sv
module sexp_sequencer #(
  parameter int SLICE_W    = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*SLICE_W-1:0] fifo_din_i,
  input  logic                 fifo_push_i,
  output logic                 fifo_full_o,
  output logic                 fifo_nopush_o,
  input  logic                 start_i,
  input  logic                 run_auto_i,
  input  logic [1:0]           x_sel_i,
  input  logic [1:0]           y_sel_i,
  input  logic [1:0]           dest_sel_i,
  output logic                 ready_o,
  output logic                 mul_start_o,
  output logic [1:0]           mul_x_o,
  output logic [1:0]           mul_y_o,
  output logic [1:0]           mul_dest_o,
  input  logic                 mul_done_i
);
  localparam int ENTRY_W = 2 * SLICE_W;

  logic [ENTRY_W-1:0] head;
  logic               empty, pop, load, shift, last;
  logic [1:0]         pair;

  sexp_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .din_i   (fifo_din_i),
    .push_i  (fifo_push_i),
    .pop_i   (pop),
    .dout_o  (head),
    .empty_o (empty),
    .full_o  (fifo_full_o),
    .nopush_o(fifo_nopush_o)
  );

  sexp_pair_shifter #(.SLICE_W(SLICE_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i (load),
    .shift_i(shift),
    .din_i  (head),
    .pair_o (pair),
    .last_o (last)
  );

  sexp_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .start_i, .run_auto_i, .x_sel_i, .y_sel_i, .dest_sel_i,
    .fifo_empty_i(empty),
    .pair_i      (pair),
    .last_i      (last),
    .mul_done_i,
    .fifo_pop_o  (pop),
    .load_o      (load),
    .shift_o     (shift),
    .mul_start_o, .mul_x_o, .mul_y_o, .mul_dest_o, .ready_o
  );
endmodule

// File: rtl/sexp_sequencer_chk.sv
module sexp_sequencer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_push_i,
  input logic       fifo_full_o,
  input logic       fifo_nopush_o,
  input logic       ready_o,
  input logic       mul_start_o,
  input logic [1:0] mul_x_o,
  input logic [1:0] mul_y_o,
  input logic [1:0] mul_dest_o,
  input logic       mul_done_i
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          busy_q <= 1'b0;
    else if (mul_start_o) busy_q <= 1'b1;
    else if (mul_done_i)  busy_q <= 1'b0;
  end

  p_ready_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_start_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_start_o |=> !mul_start_o);

  p_no_overlap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mul_start_o |-> !busy_q);

  p_sel_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> ($stable(mul_x_o) && $stable(mul_y_o) && $stable(mul_dest_o)));

  p_ready_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_q && !mul_start_o));

  p_nopush_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_push_i && fifo_full_o) |=> fifo_nopush_o);

  p_nopush_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_nopush_o |-> $past(fifo_push_i && fifo_full_o));
endmodule

bind sexp_sequencer sexp_sequencer_chk u_chk (.*);

// File: tb/sexp_sequencer_bench.sv
`timescale 1ns/1ps
module sexp_sequencer_bench;
  localparam int    DEPTH = 8;
  localparam int    LAT   = 4;
  localparam longint M    = 1000003;
  localparam longint G0   = 12345;
  localparam longint G1   = 67891;
  localparam int    NVEC  = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    32'h0000_0000, 32'h0001_0000, 32'h0000_8001,
    32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_ABCD};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fifo_din = '0;
  logic        fifo_push = 1'b0, start = 1'b0, run_auto = 1'b0, mul_done = 1'b0;
  logic [1:0]  x_sel = '0, y_sel = '0, dest_sel = '0;
  logic        fifo_full, fifo_nopush, ready, mul_start;
  logic [1:0]  mul_x, mul_y, mul_dest;

  int     n_checks = 0, n_errors = 0, mul_cnt = 0;
  longint ops [4];
  bit     prev_done = 0;

  always #2 clk = ~clk;

  sexp_sequencer #(.SLICE_W(16), .FIFO_DEPTH(DEPTH)) u_sexp_sequencer (
    .clk_i(clk), .rst_ni(rst_n),
    .fifo_din_i(fifo_din), .fifo_push_i(fifo_push),
    .fifo_full_o(fifo_full), .fifo_nopush_o(fifo_nopush),
    .start_i(start), .run_auto_i(run_auto),
    .x_sel_i(x_sel), .y_sel_i(y_sel), .dest_sel_i(dest_sel),
    .ready_o(ready), .mul_start_o(mul_start),
    .mul_x_o(mul_x), .mul_y_o(mul_y), .mul_dest_o(mul_dest),
    .mul_done_i(mul_done));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint modpow(input longint b, input logic [127:0] e);
    longint r = 1;
    longint s = b % M;
    for (int i = 0; i < 128; i++) begin
      if (e[i]) r = (r * s) % M;
      s = (s * s) % M;
    end
    return r;
  endfunction

  function automatic int popcnt(input logic [127:0] v);
    int c = 0;
    for (int i = 0; i < 128; i++) c += int'(v[i]);
    return c;
  endfunction

  // multiplier model: done LAT cycles after start, product into dest slot
  initial begin
    int rem = 0;
    logic [1:0] xa = '0, ya = '0, da = '0;
    forever begin
      @(negedge clk);
      prev_done = mul_done;
      mul_done = 1'b0;
      if (rem == 1) begin
        ops[da] = (ops[xa] * ops[ya]) % M;
        mul_done = 1'b1;
        rem = 0;
      end else if (rem > 1) begin
        rem--;
      end
      if (mul_start) begin
        xa = mul_x; ya = mul_y; da = mul_dest;
        rem = LAT;
        mul_cnt++;
      end
    end
  end

  task automatic init_ops();
    ops[0] = G0; ops[1] = G1; ops[2] = (G0 * G1) % M; ops[3] = 1;
    mul_cnt = 0;
  endtask

  task automatic push_entry(input logic [31:0] d);
    @(negedge clk);
    fifo_din = d; fifo_push = 1'b1;
    @(negedge clk);
    fifo_push = 1'b0;
  endtask

  task automatic pulse_start(input bit auto_m, input logic [1:0] xs, ys, ds);
    @(negedge clk);
    run_auto = auto_m; x_sel = xs; y_sel = ys; dest_sel = ds; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_ready(output bit seen, output bit done_before);
    seen = 0; done_before = 0;
    for (int i = 0; i < 20000 && !seen; i++) begin
      @(negedge clk);
      if (ready) begin seen = 1; done_before = prev_done; end
    end
  endtask

  task automatic run_check(input logic [127:0] e1, e0, input int nent, input string tag);
    bit seen, db;
    longint expv = (modpow(G0, e0) * modpow(G1, e1)) % M;
    pulse_start(1'b1, 2'd0, 2'd0, 2'd0);
    wait_ready(seen, db);
    check(seen, {tag, " ready"}, longint'(seen), 1);
    check(ops[3] == expv, {tag, " result R1 R2"}, ops[3], expv);
    check(mul_cnt == 16 * nent + popcnt(e0 | e1), {tag, " mul count R2"},
          mul_cnt, 16 * nent + popcnt(e0 | e1));
    @(negedge clk);
    check(!ready, {tag, " ready width R5"}, longint'(ready), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    bit seen, db;
    logic [127:0] e0a, e1a;
    // R9 reset state
    repeat (3) @(negedge clk);
    check(!ready, "R9 ready", longint'(ready), 0);
    check(!mul_start, "R9 mul_start", longint'(mul_start), 0);
    check(!fifo_full, "R9 full", longint'(fifo_full), 0);
    check(!fifo_nopush, "R9 nopush", longint'(fifo_nopush), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 table of single-entry runs
    for (int v = 0; v < NVEC; v++) begin
      init_ops();
      push_entry(VEC[v]);
      run_check({112'd0, VEC[v][31:16]}, {112'd0, VEC[v][15:0]}, 1, $sformatf("vec%0d", v));
    end

    // R3 empty queue
    init_ops();
    pulse_start(1'b1, 2'd0, 2'd0, 2'd0);
    check(ready, "R3 empty ready next cycle", longint'(ready), 1);
    @(negedge clk);
    check(mul_cnt == 0, "R3 empty no mul", mul_cnt, 0);

    // R4 single mode: slot0 = g1*g1
    init_ops();
    pulse_start(1'b0, 2'd1, 2'd1, 2'd0);
    check(mul_start, "R4 mul_start timing", longint'(mul_start), 1);
    check({mul_x, mul_y, mul_dest} == 6'b01_01_00, "R4 selects",
          longint'({mul_x, mul_y, mul_dest}), 20);
    wait_ready(seen, db);
    check(seen && db, "R4 ready after done", longint'(db), 1);
    check(ops[0] == (G1 * G1) % M, "R4 product", ops[0], (G1 * G1) % M);
    check(mul_cnt == 1, "R4 one mul", mul_cnt, 1);

    // R6 start during run ignored
    init_ops();
    push_entry(32'hFFFF_0000);
    pulse_start(1'b1, 2'd0, 2'd0, 2'd0);
    repeat (3) @(negedge clk);
    pulse_start(1'b0, 2'd0, 2'd0, 2'd1);
    wait_ready(seen, db);
    check(ops[1] == G1, "R6 slot1 untouched", ops[1], G1);
    check(mul_cnt == 32, "R6 mul count", mul_cnt, 32);
    check(ops[3] == modpow(G1, 128'hFFFF), "R6 result", ops[3], modpow(G1, 128'hFFFF));

    // R8 full queue, refused push, then multi-entry ordering run
    init_ops();
    e0a = '0; e1a = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [15:0] s1 = 16'(k * 935 + 1);
      logic [15:0] s0 = 16'(k * 81) ^ 16'h00C3;
      push_entry({s1, s0});
      e1a = (e1a << 16) | 128'(s1);
      e0a = (e0a << 16) | 128'(s0);
    end
    check(fifo_full, "R8 full", longint'(fifo_full), 1);
    push_entry(32'hFFFF_FFFF);
    check(fifo_nopush, "R8 nopush pulse", longint'(fifo_nopush), 1);
    @(negedge clk);
    check(!fifo_nopush, "R8 nopush one cycle", longint'(fifo_nopush), 0);
    run_check(e1a, e0a, DEPTH, "R8 R1 order");
    check(!fifo_full, "R8 drained", longint'(fifo_full), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule